// File: doc/BRIEF.md
# Four-Bit Ripple ALU with Set-Less-Than

This block is a purely combinational arithmetic/logic unit. It is built as a chain of identical one-bit slices. Each slice holds an AND gate, an OR gate and a full adder. The slice's b operand can optionally be complemented. A four-way result selector, made from two-input multiplexers, picks the slice output. Carries ripple from each slice's carry-out into the next slice up. The external carry input feeds bit 0.

The unit offers bitwise AND, bitwise OR, addition, subtraction and set-if-less-than. Subtraction is addition of the complemented b with a carry input of 1. For set-less-than, the raw adder sum of the top slice (the sign of a − b) is routed back to the less input of bit 0. Every other less input is tied low.

No overflow correction is applied, so set-less-than reports only that sign bit. The unit has no clock and no state, and the result settles in the same cycle as its inputs.

Top module: `ripple_slt_alu`

## Requirements
- R1: With op_sel = 2'b00, result equals a_i AND the effective b. The effective b is b_i when b_invert = 0 and ~b_i when b_invert = 1.
- R2: With op_sel = 2'b01, result equals a_i OR the effective b.
- R3: With op_sel = 2'b10, b_invert = 0 and carry_in = 0, result equals (a_i + b_i) mod 16.
- R4: With op_sel = 2'b10, b_invert = 1 and carry_in = 1, result equals (a_i − b_i) mod 16.
- R5: With op_sel = 2'b11, result bits 3 down to 1 are always 0.
- R6: With op_sel = 2'b11, result bit 0 equals bit 3 of (a_i + effective b + carry_in). With b_invert = 1 and carry_in = 1 this is the sign of a_i − b_i with no overflow correction. For example, a_i = 4'b0111 and b_i = 4'b1000 give 1.
- R7: With b_invert = 1, the AND and OR operations use ~b_i. For example, op 00 gives a_i & ~b_i.
- R8: carry_in enters bit 0 and the carries ripple upward. With op 10 and b_invert = 0, result is (a_i + b_i + carry_in) mod 16, so 4'b1111 + 0 + 1 wraps to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 4 | First operand |
| b_i | input | 4 | Second operand |
| b_invert | input | 1 | Complement b in every slice |
| carry_in | input | 1 | Carry into bit 0 |
| op_sel | input | 2 | 00 AND, 01 OR, 10 adder sum, 11 less |
| result | output | 4 | Selected result |

## Verification
Subtraction and set-less-than use the same adder in the same pass. The top slice's sum is both result bit 3 for op 10 and the value fed back into bit 0 for op 11. The bench sweeps every operand pair through both modes with b_invert and carry_in both high. It judges op 11 against the sign bit of the wrapped difference rather than a true signed compare. It also includes the overflowing pair 0111/1000, where that sign bit disagrees with the real ordering.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    ALU_AND  = 2'b00,
    ALU_OR   = 2'b01,
    ALU_ADD  = 2'b10,
    ALU_LESS = 2'b11
  } alu_op_e;
endpackage

// File: rtl/alu_mux2.sv
module alu_mux2 (
  input  logic d0,
  input  logic d1,
  input  logic sel,
  output logic y
);
  // sum-of-products form of a 2:1 selector
  assign y = (~sel & d0) | (sel & d1);
endmodule

// File: rtl/alu_mux4.sv
module alu_mux4 (
  input  logic       d0,
  input  logic       d1,
  input  logic       d2,
  input  logic       d3,
  input  logic [1:0] sel,
  output logic       y
);
  logic lo_w;
  logic hi_w;

  alu_mux2 u_lo  (.d0(d0),   .d1(d1),   .sel(sel[0]), .y(lo_w));
  alu_mux2 u_hi  (.d0(d2),   .d1(d3),   .sel(sel[0]), .y(hi_w));
  alu_mux2 u_out (.d0(lo_w), .d1(hi_w), .sel(sel[1]), .y(y));
endmodule

// File: rtl/alu_full_adder.sv
module alu_full_adder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & ci) | (y & ci) | (x & y);
endmodule

// File: rtl/alu_slice.sv
module alu_slice (
  input  logic       a,
  input  logic       b,
  input  logic       less,
  input  logic       binv,
  input  logic       cin,
  input  logic [1:0] op,
  output logic       res,
  output logic       sum,
  output logic       cout
);
  logic b_eff;
  logic and_w;
  logic or_w;

  alu_mux2 u_binv (.d0(b), .d1(~b), .sel(binv), .y(b_eff));

  assign and_w = a & b_eff;
  assign or_w  = a | b_eff;

  alu_full_adder u_fa (.x(a), .y(b_eff), .ci(cin), .s(sum), .co(cout));

  alu_mux4 u_sel (
    .d0(and_w), .d1(or_w), .d2(sum), .d3(less),
    .sel(op), .y(res)
  );
endmodule

// File: rtl/ripple_slt_alu.sv
module ripple_slt_alu #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             b_invert,
  input  logic             carry_in,
  input  logic [1:0]       op_sel,
  output logic [WIDTH-1:0] result
);
  import alu_pkg::*;

  localparam int MSB = WIDTH - 1;

  logic             set_w;
  logic [WIDTH-1:0] sum_w;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic cin_l;
    logic cout_l;
    logic sum_l;
    logic less_l;

    if (i == 0) begin : g_lsb
      assign cin_l  = carry_in;
      assign less_l = set_w;
    end else begin : g_upper
      assign cin_l  = g_bit[i-1].cout_l;
      assign less_l = 1'b0;
    end

    alu_slice u_slice (
      .a(a_i[i]), .b(b_i[i]), .less(less_l),
      .binv(b_invert), .cin(cin_l), .op(op_sel),
      .res(result[i]), .sum(sum_l), .cout(cout_l)
    );

    assign sum_w[i] = sum_l;

    if (i == MSB) begin : g_set
      assign set_w = sum_l;
    end
  end

  // Checks against a behavioural reference built apart from the slice chain
  logic [WIDTH-1:0] b_ref;
  logic [WIDTH-1:0] add_ref;
  assign b_ref   = b_invert ? ~b_i : b_i;
  assign add_ref = a_i + b_ref + WIDTH'(carry_in);

  always_comb begin : chk
    assert_ripple_sum_R8: assert (sum_w == add_ref);
    if (op_sel == ALU_AND) begin
      assert_and_R1: assert (result == (a_i & b_ref));
    end
    if (op_sel == ALU_OR) begin
      assert_or_R2: assert (result == (a_i | b_ref));
    end
    if (op_sel == ALU_ADD) begin
      assert_add_R3: assert (result == add_ref);
    end
    if (op_sel == ALU_LESS) begin
      assert_less_hi_zero_R5: assert (result[MSB:1] == '0);
      assert_less_sign_R6:    assert (result[0] == add_ref[MSB]);
    end
  end
endmodule

// File: tb/tb_ripple_slt_alu.sv
module tb_ripple_slt_alu;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 20000;

  logic       clk;
  logic       rst_n;
  logic [3:0] a_i;
  logic [3:0] b_i;
  logic       b_invert;
  logic       carry_in;
  logic [1:0] op_sel;
  logic [3:0] result;

  int checks;
  int fails;
  bit done;

  logic [3:0] exp_q[$];
  string      tag_q[$];

  ripple_slt_alu dut (
    .a_i(a_i), .b_i(b_i), .b_invert(b_invert),
    .carry_in(carry_in), .op_sel(op_sel), .result(result)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference from the requirement text
  function automatic logic [3:0] model(input logic [3:0] a, input logic [3:0] b,
                                       input logic bi, input logic ci,
                                       input logic [1:0] op);
    logic [3:0] be;
    logic [3:0] s;
    be = bi ? ~b : b;
    s  = a + be + {3'b000, ci};
    case (op)
      2'b00:   return a & be;
      2'b01:   return a | be;
      2'b10:   return s;
      default: return {3'b000, s[3]};
    endcase
  endfunction

  task automatic drive(input logic [3:0] a, input logic [3:0] b,
                       input logic bi, input logic ci,
                       input logic [1:0] op, input string tag);
    @(posedge clk);
    a_i = a; b_i = b; b_invert = bi; carry_in = ci; op_sel = op;
    exp_q.push_back(model(a, b, bi, ci, op));
    tag_q.push_back(tag);
  endtask

  task automatic push_literal(input logic [3:0] a, input logic [3:0] b,
                              input logic bi, input logic ci, input logic [1:0] op,
                              input logic [3:0] exp, input string tag);
    @(posedge clk);
    a_i = a; b_i = b; b_invert = bi; carry_in = ci; op_sel = op;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare one queued item per cycle, away from the driving edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (result !== e) begin
        fails++;
        $display("FAIL %s: a=%b b=%b binv=%b cin=%b op=%b actual=%b expected=%b",
                 t, a_i, b_i, b_invert, carry_in, op_sel, result, e);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    checks = 0; fails = 0; done = 1'b0;
    rst_n = 1'b0;
    a_i = '0; b_i = '0; b_invert = 1'b0; carry_in = 1'b0; op_sel = 2'b00;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give zero (R1 with AND)
    push_literal(4'h0, 4'h0, 1'b0, 1'b0, 2'b00, 4'h0, "R1 idle");

    // Directed corner cases
    push_literal(4'b1100, 4'b1010, 1'b0, 1'b0, 2'b00, 4'b1000, "R1 and");
    push_literal(4'b1100, 4'b1010, 1'b0, 1'b0, 2'b01, 4'b1110, "R2 or");
    push_literal(4'b1100, 4'b1010, 1'b1, 1'b0, 2'b00, 4'b0100, "R7 and-not");
    push_literal(4'b0100, 4'b1010, 1'b1, 1'b0, 2'b01, 4'b0101, "R7 or-not");
    push_literal(4'b0111, 4'b0001, 1'b0, 1'b0, 2'b10, 4'b1000, "R3 add");
    push_literal(4'b1111, 4'b0000, 1'b0, 1'b1, 2'b10, 4'b0000, "R8 wrap");
    push_literal(4'b0011, 4'b0101, 1'b1, 1'b1, 2'b10, 4'b1110, "R4 sub");
    push_literal(4'b0011, 4'b0101, 1'b1, 1'b1, 2'b11, 4'b0001, "R6 slt true");
    push_literal(4'b0101, 4'b0011, 1'b1, 1'b1, 2'b11, 4'b0000, "R6 slt false");
    push_literal(4'b0111, 4'b1000, 1'b1, 1'b1, 2'b11, 4'b0001, "R6 slt overflow");
    push_literal(4'b1111, 4'b1111, 1'b1, 1'b1, 2'b11, 4'b0000, "R5 slt equal");

    // Exhaustive sweeps per mode
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        drive(4'(a), 4'(b), 1'b0, 1'b0, 2'b00, "R1 sweep");
        drive(4'(a), 4'(b), 1'b0, 1'b0, 2'b01, "R2 sweep");
        drive(4'(a), 4'(b), 1'b0, 1'b0, 2'b10, "R3 sweep");
        drive(4'(a), 4'(b), 1'b0, 1'b1, 2'b10, "R8 sweep");
        drive(4'(a), 4'(b), 1'b1, 1'b1, 2'b10, "R4 sweep");
        drive(4'(a), 4'(b), 1'b1, 1'b1, 2'b11, "R5 R6 sweep");
        drive(4'(a), 4'(b), 1'b1, 1'b0, 2'b01, "R7 sweep");
      end
    end

    repeat (3) @(posedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule